// File: doc/BRIEF.md
# Periodic System Tick Timer

A 24-bit down-counter that produces a periodic event for an operating system tick or any fixed-interval wakeup. Software loads a reload value, picks the count source and enables the counter. The count source is either every processor clock cycle or a single-cycle enable strobe derived from a slower reference clock. When the count steps from 1 to 0 the block raises a sticky status flag and, if interrupts are enabled, pulses its interrupt request. On the next count tick the counter reloads, so a reload value of N gives one event every N+1 ticks.

Four 32-bit registers sit on a simple read/write strobe bus, selected by a two-bit word index. Index 0 is control and status. Index 1 is the reload value. Index 2 is the live count. Index 3 is a fixed calibration word. The calibration word comes from parameters and tells software how many ticks make 10 ms, whether that figure is exact, and whether a reference clock exists at all. When no reference clock exists, the source select is stuck at the processor clock.

Top module: `tick_timer`

## Requirements
- R1: Control word (index 0): bit 0 enables counting, bit 1 enables the interrupt, bit 2 selects the source (1 = processor clock, 0 = reference strobe), bit 16 is the count-to-zero flag; every other bit reads 0 and bits 0..2 read back as written.
- R2: The reload word (index 1) and the count word (index 2) hold 24 bits; bits 31:24 of both always read 0.
- R3: With reload R (1..0xFFFFFF), the 1-to-0 step of the count, and with it the event, repeats every R+1 ticks; a tick at count 0 loads R.
- R4: With source select 0, the counter advances only in cycles where `ref_tick` is high; with select 1 it advances every cycle.
- R5: Any write to index 2, whatever the data, sets the count to 0 and clears the count-to-zero flag.
- R6: The count-to-zero flag is set by each 1-to-0 step and stays set until the control word is read; that read returns 1 in bit 16 and the next read returns 0.
- R7: `irq` is high for exactly one cycle, the cycle after each 1-to-0 step, and only if the interrupt enable was set; with it clear, the flag still sets but `irq` stays low.
- R8: Index 3 reads {no-reference bit at 31, inexact bit at 30, zeros at 29:24, 10 ms count at 23:0} from parameters; writes to it change nothing.
- R9: When the no-reference parameter is 1, control bit 2 reads 1 even after writing 0, and the counter runs on the processor clock.
- R10: With reload 0, the enabled counter stays at 0 and produces no events.
- R11: While the enable bit is 0, the count holds its value.
- R12: After reset, the control, reload and count words read 0 (control bit 2 reads 1 if there is no reference clock) and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe; data valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (0 when not reading) |
| ref_tick | input | 1 | One-cycle enable from the reference clock domain |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench sweeps small reload values on both count sources and measures the cycle distance between interrupt pulses. An off-by-one in the reload path would show up as a period of R or R+2 ticks, and a source mix-up would show up as a period that is not three times longer on the reference strobe. It also checks the sticky flag across a read followed by a second read, and checks that a write to the count word clears both the count and a pending flag; a design that cleared on write only, or cleared the flag before returning it, would read the wrong bit 16. Reload 0, truncation of the upper byte, the writes ignored by the calibration word, and a second instance built without a reference clock are covered too. That instance must keep its source bit at 1 and keep counting while the reference strobe is idle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_COUNT   = 2'd2,
        SEL_CALIB   = 2'd3
    } reg_sel_e;

    // control word bit positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_SRC_BIT  = 2;
    localparam int CTRL_FLAG_BIT = 16;

    // calibration word layout
    localparam int CAL_CNT_W     = 24;
    localparam int CAL_SKEW_BIT  = 30;
    localparam int CAL_NOREF_BIT = 31;

    typedef struct packed {
        logic clksrc;
        logic tickint;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/tick_ctrl_regs.sv
module tick_ctrl_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter bit CAL_NOREF = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_reload,
    input  logic [BUS_W-1:0] wdata,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] reload_o
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) begin
            regs_d.ctrl.enable  = wdata[CTRL_EN_BIT];
            regs_d.ctrl.tickint = wdata[CTRL_IE_BIT];
            regs_d.ctrl.clksrc  = wdata[CTRL_SRC_BIT];
        end
        if (wr_reload) begin
            regs_d.reload = wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl_o.enable  = regs_q.ctrl.enable;
    assign ctrl_o.tickint = regs_q.ctrl.tickint;

    generate
        if (CAL_NOREF) begin : g_noref
            // no reference clock: source select is stuck at processor clock
            assign ctrl_o.clksrc = 1'b1;
        end else begin : g_ref
            assign ctrl_o.clksrc = regs_q.ctrl.clksrc;
        end
    endgenerate

    assign reload_o = regs_q.reload;

endmodule

// File: rtl/tick_counter.sv
module tick_counter
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] reload,
    input  logic             ref_tick,
    input  logic             clr_count,
    input  logic             rd_status,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             flag;
        logic             irq;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       tick;
    logic       hit;

    assign tick = ctrl.enable && (ctrl.clksrc || ref_tick);

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        hit      = 1'b0;
        if (clr_count) begin
            st_d.count = '0;
            st_d.flag  = 1'b0;
        end else begin
            if (tick) begin
                if (st_q.count == '0) begin
                    st_d.count = reload;
                end else begin
                    st_d.count = st_q.count - ONE;
                    hit        = (st_q.count == ONE);
                end
            end
            if (hit) begin
                st_d.flag = 1'b1;
                st_d.irq  = ctrl.tickint;
            end else if (rd_status) begin
                st_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign flag_o  = st_q.flag;
    assign irq_o   = st_q.irq;

endmodule

// File: rtl/tick_rdmux.sv
module tick_rdmux
    import tick_timer_pkg::*;
#(
    parameter int                   CNT_W     = 24,
    parameter logic [CAL_CNT_W-1:0] CAL_TENMS = '0,
    parameter bit                   CAL_SKEW  = 1'b0,
    parameter bit                   CAL_NOREF = 1'b0
) (
    input  logic             rd_en,
    input  reg_sel_e         sel,
    input  ctrl_t            ctrl,
    input  logic             flag,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] count,
    output logic [BUS_W-1:0] rdata
);

    localparam logic [BUS_W-1:0] CAL_WORD =
        (BUS_W'(CAL_NOREF) << CAL_NOREF_BIT) |
        (BUS_W'(CAL_SKEW)  << CAL_SKEW_BIT)  |
        BUS_W'(CAL_TENMS);

    logic [BUS_W-1:0] ctrl_word;

    always_comb begin
        ctrl_word                = '0;
        ctrl_word[CTRL_EN_BIT]   = ctrl.enable;
        ctrl_word[CTRL_IE_BIT]   = ctrl.tickint;
        ctrl_word[CTRL_SRC_BIT]  = ctrl.clksrc;
        ctrl_word[CTRL_FLAG_BIT] = flag;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_CTRL:   rdata = ctrl_word;
                SEL_RELOAD: rdata = BUS_W'(reload);
                SEL_COUNT:  rdata = BUS_W'(count);
                SEL_CALIB:  rdata = CAL_WORD;
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int                   CNT_W     = 24,
    parameter logic [CAL_CNT_W-1:0] CAL_TENMS = 24'h0F423F,
    parameter bit                   CAL_SKEW  = 1'b0,
    parameter bit                   CAL_NOREF = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ref_tick,
    output logic        irq
);

    reg_sel_e         sel;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             flag;
    logic             wr_ctrl, wr_reload, clr_count, rd_status;

    assign sel       = reg_sel_e'(bus_addr);
    assign wr_ctrl   = bus_wr && (sel == SEL_CTRL);
    assign wr_reload = bus_wr && (sel == SEL_RELOAD);
    assign clr_count = bus_wr && (sel == SEL_COUNT);
    assign rd_status = bus_rd && (sel == SEL_CTRL);

    tick_ctrl_regs #(
        .CNT_W     (CNT_W),
        .CAL_NOREF (CAL_NOREF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_reload (wr_reload),
        .wdata     (bus_wdata),
        .ctrl_o    (ctrl),
        .reload_o  (reload)
    );

    tick_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .reload    (reload),
        .ref_tick  (ref_tick),
        .clr_count (clr_count),
        .rd_status (rd_status),
        .count_o   (count),
        .flag_o    (flag),
        .irq_o     (irq)
    );

    tick_rdmux #(
        .CNT_W     (CNT_W),
        .CAL_TENMS (CAL_TENMS),
        .CAL_SKEW  (CAL_SKEW),
        .CAL_NOREF (CAL_NOREF)
    ) u_rd (
        .rd_en  (bus_rd),
        .sel    (sel),
        .ctrl   (ctrl),
        .flag   (flag),
        .reload (reload),
        .count  (count),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 24,
    parameter bit NOREF = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             irq,
    input logic [CNT_W-1:0] count,
    input logic             flag,
    input logic             en,
    input logic             tickint
);

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tickint)); // R7

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == '0) && $past(count) == CNT_W'(1)); // R3

    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R6

    AST_COUNT_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> (count == '0) && !flag); // R5

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !(bus_wr && bus_addr == 2'd2)) |=> $stable(count)); // R11

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == 2'd1 || bus_addr == 2'd2)) |-> (bus_rdata[31:24] == 8'h00)); // R2

    AST_NOREF_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (NOREF && bus_rd && bus_addr == 2'd0) |-> bus_rdata[2]); // R9

endmodule

bind tick_timer tick_timer_chk #(
    .CNT_W (CNT_W),
    .NOREF (CAL_NOREF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .count     (count),
    .flag      (flag),
    .en        (ctrl.enable),
    .tickint   (ctrl.tickint)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;

    localparam realtime HALF = 2.0;
    localparam logic [23:0] TENMS0 = 24'h0F423F;
    localparam logic [23:0] TENMS1 = 24'h002710;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        ref_tick = 1'b0;
    logic        ref_on = 1'b0;
    logic        irq0, irq1;

    int checks = 0, fails = 0;
    int cyc = 0;
    int n_irq0 = 0, n_irq1 = 0;
    int last_irq = 0, prev_irq = 0;

    always #(HALF) clk = ~clk;

    tick_timer #(.CAL_TENMS(TENMS0), .CAL_SKEW(1'b1), .CAL_NOREF(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
        .ref_tick(ref_tick), .irq(irq0));

    tick_timer #(.CAL_TENMS(TENMS1), .CAL_SKEW(1'b0), .CAL_NOREF(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
        .ref_tick(ref_tick), .irq(irq1));

    always @(posedge clk) cyc <= cyc + 1;

    // reference strobe: one cycle in three
    always @(negedge clk) ref_tick <= ref_on && (cyc % 3 == 0);

    always @(negedge clk) begin
        if (irq0) begin
            prev_irq = last_irq;
            last_irq = cyc;
            n_irq0++;
        end
        if (irq1) n_irq1++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v0, output logic [31:0] v1);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        v0 = rdata0; v1 = rdata1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] a, b, c, d;
        int base, base1, t;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        rd(2'd0, a, b);
        chk("R12 ctrl u0", a, 32'h0);
        chk("R12 ctrl u1", b, 32'h4);
        rd(2'd1, a, b);
        chk("R12 reload", a, 32'h0);
        rd(2'd2, a, b);
        chk("R12 count", a, 32'h0);
        chk("R12 irq", {31'b0, irq0}, 32'h0);

        // R8: calibration words, writes ignored
        wr(2'd3, 32'h0);
        rd(2'd3, a, b);
        chk("R8 calib u0", a, {1'b0, 1'b1, 6'b0, TENMS0});
        chk("R8 calib u1", b, {1'b1, 1'b0, 6'b0, TENMS1});

        // R1: control word layout (reload 0, so no events)
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, a, b);
        chk("R1 ctrl all-ones", a, 32'h7);
        wr(2'd0, 32'h0);
        rd(2'd0, a, b);
        chk("R1 ctrl cleared", a, 32'h0);
        chk("R9 src stuck", b, 32'h4);

        // R2: reload truncation
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, a, b);
        chk("R2 reload upper", a, 32'h00FF_FFFF);

        // R10: reload zero keeps counter idle
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0);
        base = n_irq0;
        wr(2'd0, 32'h7);
        idle(40);
        rd(2'd2, a, b);
        chk("R10 count stays 0", a, 32'h0);
        chk("R10 no events", n_irq0 - base, 32'h0);

        // R3 / R4: period sweep on both sources
        for (int src = 1; src >= 0; src--) begin
            ref_on = (src == 0);
            for (int r = 1; r <= 8; r++) begin
                wr(2'd0, 32'h0);
                wr(2'd1, r);
                wr(2'd2, 32'h0);
                base = n_irq0;
                wr(2'd0, {29'b0, src[0], 2'b11});
                t = 0;
                while (n_irq0 < base + 2 && t < 400) begin
                    @(negedge clk);
                    t++;
                end
                if (src == 1)
                    chk("R3 period proc clk", last_irq - prev_irq, r + 1);
                else
                    chk("R4 period ref strobe", last_irq - prev_irq, 3 * (r + 1));
            end
        end
        ref_on = 1'b0;

        // R6 / R7: flag without interrupt, cleared by reading
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd4);
        wr(2'd2, 32'h0);
        base = n_irq0;
        wr(2'd0, 32'h5);
        idle(30);
        wr(2'd0, 32'h4);
        chk("R7 no irq without enable", n_irq0 - base, 32'h0);
        rd(2'd0, a, b);
        chk("R6 flag set", a, 32'h0001_0004);
        rd(2'd0, a, b);
        chk("R6 flag cleared by read", a, 32'h4);

        // R5: write to count zeroes it and drops the flag
        wr(2'd0, 32'h5);
        idle(30);
        wr(2'd0, 32'h4);
        wr(2'd2, 32'hDEAD_BEEF);
        rd(2'd2, a, b);
        chk("R5 count zeroed", a, 32'h0);
        rd(2'd0, a, b);
        chk("R5 flag cleared by count write", a, 32'h4);

        // R11: disabled counter holds
        wr(2'd1, 32'd50);
        wr(2'd0, 32'h5);
        idle(10);
        wr(2'd0, 32'h4);
        rd(2'd2, a, b);
        idle(20);
        rd(2'd2, c, d);
        chk("R11 count held", c, a);
        chk("R11 count in range", {31'b0, (a != 0) && (a <= 50)}, 32'h1);

        // R2: count upper byte reads zero near full scale
        wr(2'd1, 32'h00FF_FFFF);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h5);
        idle(5);
        rd(2'd2, a, b);
        chk("R2 count upper zero", {24'b0, a[31:24]}, 32'h0);
        chk("R2 count near top", {31'b0, a >= 32'h00FF_FF00}, 32'h1);

        // R9: no reference clock -> runs on processor clock with strobe idle
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd20);
        wr(2'd2, 32'h0);
        base1 = n_irq1;
        base = n_irq0;
        wr(2'd0, 32'h3);
        idle(30);
        rd(2'd2, a, b);
        chk("R9 u0 idle on strobe", a, 32'h0);
        chk("R9 u1 counting", {31'b0, b != 0}, 32'h1);
        chk("R9 u1 events", {31'b0, (n_irq1 - base1) > 0}, 32'h1);
        chk("R4 u0 no events", n_irq0 - base, 32'h0);
        rd(2'd0, a, b);
        chk("R9 u1 src bit", {29'b0, b[2:0]}, 32'h7);

        summary();
        $finish;
    end

endmodule